// File: doc/BRIEF.md
# Indexed Vector Element Sequencer

This block schedules a vector operation one element at a time, in vertical-first order. It keeps an element counter that runs from 0 to VL-1. For that element it produces a register number and a half-register select for each of four operand slots: destination, first source, second source and third source. A slot can take a plain linear element number. It can also be remapped to one of four shapes. A shape either reads a small index from a table of packed indices, or yields the element counter taken modulo a configured value. The index is added to the slot's base register position. The result is then split into a register number and a sub-element select, according to the operation width.

The addresses for each element leave as a valid/ready stream. `out_valid` stays high while a loop is running, and the payload holds still until `out_ready` accepts it. Each accepted beat is one step. `out_last` marks the final element of a pass. After that beat the counter returns to zero and an outer pass counter counts down. When the outer counter reaches zero the stream stops and `loop_done` is raised. One configuration port covers four jobs: it loads table words addressed by register number, it sets up each shape, it sets the slot remapping, and it starts a loop.

Top module: `elem_sequencer`

## Requirements
- R1: After reset, `out_valid` and `loop_done` are both low.
- R2: A configuration write of kind 3 (loop) starts a loop, and the new loop replaces any loop already running. The write carries the vector length in `cfg_data[7:0]`: 0 is taken as 1, and values above MAXVL are clamped to MAXVL. It carries the operation width in `cfg_data[8]` (0 = one 64-bit element per register, 1 = two 32-bit elements) and the outer pass count in `cfg_data[31:16]`. If the count is nonzero, `out_valid` is high with `out_elem` = 0 in the cycle after the write.
- R3: Each cycle with `out_valid` and `out_ready` both high advances `out_elem` by one. While `out_ready` is low, the element number and every address output hold steady.
- R4: `out_last` is high exactly when `out_elem` equals VL-1. Accepting that beat returns the element number to 0 and lowers the outer count by one.
- R5: When the outer count reaches zero, `out_valid` goes low and `loop_done` goes high. A loop started with a count of zero raises `loop_done` at once and produces no beats.
- R6: A slot whose remap enable is clear uses the element number itself as its index.
- R7: A table shape with element-width code c (held in shape data bits [1:0]) holds 2^c indices, each 64>>c bits wide, in every 64-bit word, little-endian, so element 0 sits in the least significant bits. Element e reads word (e>>c) modulo MAXVL/8, and only the low REGW+1 bits of the index are used.
- R8: A shape with shape data bit [2] set ignores its table and yields the element number modulo N, where N is shape data bits [15:8]. An N of 0 or 1 yields 0. The value restarts at each pass.
- R9: With index i and base register B, the element position is p = B*2 + i when the operation width is 32-bit, and p = B + i when it is 64-bit. The register output is p>>1 or p respectively, taken modulo 2^REGW. The half select is p&1 for 32-bit operation and 0 for 64-bit operation.
- R10: A kind-2 (remap) write sets slot k from bits [3k+2:3k]: bit 3k+2 enables remapping, and bits [3k+1:3k] pick the shape. Slot 0 is the destination, slot 1 the first source, slot 2 the second source and slot 3 the third source.
- R11: A kind-1 (shape) write configures the shape named by `cfg_addr[1:0]`. Its table home register is twice the value in shape data bits [16+REGW-2:16], so only even registers can be named. A kind-0 (table) write to register number `cfg_addr` stores `cfg_data` as word (`cfg_addr` - home) of every shape whose home window of MAXVL/8 registers covers that register. The write is ignored for all other shapes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 table word, 1 shape, 2 remap, 3 loop start |
| cfg_addr | input | REGW | Register number (table) or shape number (shape) |
| cfg_data | input | 64 | Configuration payload |
| slot_base | input | NSLOT x REGW | Base register per operand slot |
| out_valid | output | 1 | Element addresses are valid |
| out_ready | input | 1 | Consumer accepts the current element (step) |
| out_elem | output | log2(MAXVL) | Current element number |
| out_last | output | 1 | Current element is the last of the pass |
| out_reg | output | NSLOT x REGW | Register number per slot |
| out_half | output | NSLOT | Sub-element select per slot |
| loop_done | output | 1 | Outer pass count has reached zero |

## Verification
The first pattern is a full 32-element run with two outer passes and random back-pressure. Its slots use an 8-bit index table, a 32-bit index table whose words were partly overwritten through an overlapping home window, a modulo-4 shape and a linear slot, all at 32-bit operation width. This separates the byte order, the word selection, the half-select split and the wrap between passes. A second pattern switches to 64-bit operation, 64-bit indices with junk in their upper bits and a modulo-3 shape over a 5-element vector, and it stalls the stream first. This shows whether indices are masked, whether the modulus follows the configuration and whether stalled outputs hold. Zero-length and zero-count loops test the clamping and the immediate completion. Table writes to uncovered registers, and to a shape in modulo mode, must leave every address unchanged.

// File: rtl/eseq_pkg.sv
package eseq_pkg;

  localparam int NSHAPE = 4;
  localparam int SHW    = 2;

  typedef enum logic [1:0] {
    CFG_TABLE = 2'd0,
    CFG_SHAPE = 2'd1,
    CFG_REMAP = 2'd2,
    CFG_LOOP  = 2'd3
  } cfg_kind_e;

  typedef struct packed {
    logic       is_mod;
    logic [1:0] elw;
    logic [7:0] modn;
  } shape_cfg_t;

  typedef struct packed {
    logic           en;
    logic [SHW-1:0] sel;
  } remap_t;

endpackage

// File: rtl/eseq_index_store.sv
// Per-shape packed index tables, written by register number through a home
// window, and read out as one index per shape for the current element.
module eseq_index_store #(
  parameter int REGW      = 7,
  parameter int EW        = 5,
  parameter int TBL_WORDS = 4,
  parameter int IDXU      = 8,
  parameter int NSHAPE    = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [REGW-1:0]                   wr_reg,
  input  logic [63:0]                       wr_data,
  input  logic [NSHAPE-1:0][REGW-1:0]       home,
  input  logic [NSHAPE-1:0][1:0]            elw,
  input  logic [EW-1:0]                     elem,
  output logic [NSHAPE-1:0][IDXU-1:0]       idx_o
);

  localparam int TWW = $clog2(TBL_WORDS);

  for (genvar s = 0; s < NSHAPE; s++) begin : g_shape
    logic [63:0]     words [TBL_WORDS];
    logic [REGW:0]   diff;
    logic            hit;
    logic [EW-1:0]   wsh;
    logic [2:0]      submask;
    logic [2:0]      sub;
    logic [5:0]      boff;
    logic [63:0]     shifted;
    logic [IDXU-1:0] wmask;

    always_comb begin
      diff = {1'b0, wr_reg} - {1'b0, home[s]};
      hit  = !diff[REGW] && (diff[REGW-1:0] < REGW'(TBL_WORDS));
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int w = 0; w < TBL_WORDS; w++) words[w] <= '0;
      end else if (wr_en && hit) begin
        words[diff[TWW-1:0]] <= wr_data;
      end
    end

    always_comb begin
      wsh     = elem >> elw[s];
      submask = 3'((4'd1 << elw[s]) - 4'd1);
      sub     = elem[2:0] & submask;
      boff    = 6'({3'b000, sub} << (3'd6 - {1'b0, elw[s]}));
      shifted = words[wsh[TWW-1:0]] >> boff;
      for (int i = 0; i < IDXU; i++) wmask[i] = (i < (64 >> elw[s]));
      idx_o[s] = shifted[IDXU-1:0] & wmask;
    end
  end

endmodule

// File: rtl/eseq_mod_counter.sv
// Running element count modulo a configured value, restarted per pass.
module eseq_mod_counter #(
  parameter int EW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          adv,
  input  logic [7:0]    modn,
  output logic [EW-1:0] value
);

  localparam int CW = (EW > 8) ? EW : 8;

  logic [CW-1:0] v_ext;
  logic [CW-1:0] n_ext;
  logic          at_top;

  always_comb begin
    v_ext  = CW'(value);
    n_ext  = CW'(modn);
    at_top = (n_ext <= CW'(1)) || (v_ext == n_ext - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       value <= '0;
    else if (clear)   value <= '0;
    else if (adv)     value <= at_top ? '0 : value + EW'(1);
  end

  AST_MOD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clear && modn > 8'd1 && CW'(value) < CW'(modn) - CW'(1))
      |=> value == $past(value) + EW'(1)); // R8

  AST_MOD_TRIVIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && modn <= 8'd1) |=> value == '0); // R8

endmodule

// File: rtl/eseq_slot_addr.sv
// One operand slot: choose linear or remapped index, add to base, split.
module eseq_slot_addr #(
  parameter int REGW   = 7,
  parameter int EW     = 5,
  parameter int IDXU   = 8,
  parameter int NSHAPE = 4
) (
  input  logic                        opw,
  input  logic [REGW-1:0]             base,
  input  logic [EW-1:0]               elem,
  input  eseq_pkg::remap_t            rmp,
  input  logic [NSHAPE-1:0][IDXU-1:0] shape_idx,
  output logic [REGW-1:0]             reg_num,
  output logic                        half
);

  logic [IDXU-1:0] idx;
  logic [REGW:0]   pos;

  always_comb begin
    idx     = rmp.en ? shape_idx[rmp.sel] : IDXU'(elem);
    pos     = (opw ? {base, 1'b0} : {1'b0, base}) + (REGW+1)'(idx);
    reg_num = opw ? pos[REGW:1] : pos[REGW-1:0];
    half    = opw & pos[0];
  end

endmodule

// File: rtl/elem_sequencer.sv
module elem_sequencer #(
  parameter int MAXVL = 32,   // power of two, at least 16
  parameter int REGW  = 7,
  parameter int NSLOT = 4,
  parameter int OUTW  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_kind,
  input  logic [REGW-1:0]            cfg_addr,
  input  logic [63:0]                cfg_data,
  input  logic [NSLOT-1:0][REGW-1:0] slot_base,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [$clog2(MAXVL)-1:0]   out_elem,
  output logic                       out_last,
  output logic [NSLOT-1:0][REGW-1:0] out_reg,
  output logic [NSLOT-1:0]           out_half,
  output logic                       loop_done
);
  import eseq_pkg::*;

  localparam int EW        = $clog2(MAXVL);
  localparam int VLW       = EW + 1;
  localparam int TBL_WORDS = MAXVL / 8;
  localparam int IDXU      = REGW + 1;

  shape_cfg_t                   shp    [NSHAPE];
  logic [NSHAPE-1:0][REGW-1:0]  home;
  logic [NSHAPE-1:0][1:0]       elw_v;
  remap_t                       remap  [NSLOT];
  logic [VLW-1:0]               vl;
  logic                         opw;
  logic [OUTW-1:0]              outer;
  logic                         loaded;
  logic [EW-1:0]                elem;

  logic                         wr_table, wr_shape, wr_remap, wr_loop;
  logic                         xfer, last, pass_end;
  logic [VLW-1:0]               vl_new;
  logic [NSHAPE-1:0][IDXU-1:0]  tbl_idx;
  logic [NSHAPE-1:0][IDXU-1:0]  shp_idx;
  logic [NSHAPE-1:0][EW-1:0]    modv;

  always_comb begin
    wr_table = cfg_we && (cfg_kind == CFG_TABLE);
    wr_shape = cfg_we && (cfg_kind == CFG_SHAPE);
    wr_remap = cfg_we && (cfg_kind == CFG_REMAP);
    wr_loop  = cfg_we && (cfg_kind == CFG_LOOP);
    if (cfg_data[7:0] == 8'd0)                 vl_new = VLW'(1);
    else if (32'(cfg_data[7:0]) > MAXVL)       vl_new = VLW'(MAXVL);
    else                                       vl_new = VLW'(cfg_data[7:0]);
    out_valid = loaded && (outer != '0);
    loop_done = loaded && (outer == '0);
    last      = ({1'b0, elem} == vl - VLW'(1));
    xfer      = out_valid && out_ready;
    pass_end  = xfer && last;
  end

  // shape and remap configuration
  for (genvar s = 0; s < NSHAPE; s++) begin : g_shape_cfg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shp[s]  <= '0;
        home[s] <= '0;
      end else if (wr_shape && cfg_addr[SHW-1:0] == SHW'(s)) begin
        shp[s].elw    <= cfg_data[1:0];
        shp[s].is_mod <= cfg_data[2];
        shp[s].modn   <= cfg_data[15:8];
        home[s]       <= {cfg_data[16 +: REGW-1], 1'b0};
      end
    end
    assign elw_v[s] = shp[s].elw;

    eseq_mod_counter #(.EW(EW)) u_mod (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (wr_loop || pass_end),
      .adv   (xfer),
      .modn  (shp[s].modn),
      .value (modv[s])
    );

    assign shp_idx[s] = shp[s].is_mod ? IDXU'(modv[s]) : tbl_idx[s];
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)        remap[k] <= '0;
      else if (wr_remap) remap[k] <= cfg_data[3*k +: 3];
    end

    eseq_slot_addr #(.REGW(REGW), .EW(EW), .IDXU(IDXU), .NSHAPE(NSHAPE)) u_addr (
      .opw       (opw),
      .base      (slot_base[k]),
      .elem      (elem),
      .rmp       (remap[k]),
      .shape_idx (shp_idx),
      .reg_num   (out_reg[k]),
      .half      (out_half[k])
    );
  end

  eseq_index_store #(
    .REGW(REGW), .EW(EW), .TBL_WORDS(TBL_WORDS), .IDXU(IDXU), .NSHAPE(NSHAPE)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_table),
    .wr_reg  (cfg_addr),
    .wr_data (cfg_data),
    .home    (home),
    .elw     (elw_v),
    .elem    (elem),
    .idx_o   (tbl_idx)
  );

  // loop control: element counter and outer pass counter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl     <= VLW'(1);
      opw    <= 1'b0;
      outer  <= '0;
      loaded <= 1'b0;
      elem   <= '0;
    end else if (wr_loop) begin
      vl     <= vl_new;
      opw    <= cfg_data[8];
      outer  <= cfg_data[16 +: OUTW];
      loaded <= 1'b1;
      elem   <= '0;
    end else if (xfer) begin
      elem <= last ? '0 : elem + EW'(1);
      if (last) outer <= outer - OUTW'(1);
    end
  end

  assign out_elem = elem;
  assign out_last = out_valid && last;

  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_loop |=> out_elem == '0); // R2

  AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !last && !cfg_we) |=> out_elem == $past(out_elem) + EW'(1)); // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !cfg_we) |=> out_valid && $stable(out_elem) && $stable(out_reg)
      && $stable(out_half)); // R3

  AST_PASS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_end && !cfg_we) |=> out_elem == '0 && outer == $past(outer) - OUTW'(1)); // R4

  AST_ELEM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> {1'b0, out_elem} < vl); // R4

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done |-> !out_valid && !out_last); // R5

  AST_HALF_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !opw) |-> out_half == '0); // R9

endmodule

// File: tb/tb_elem_sequencer.sv
module tb_elem_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int MAXVL = 32;
  localparam int REGW  = 7;
  localparam int NSLOT = 4;

  typedef struct packed {
    logic [4:0]       elem;
    logic             last;
    logic [3:0][6:0]  regs;
    logic [3:0]       halves;
  } item_t;

  logic                       clk = 1'b0;
  logic                       rst_n = 1'b0;
  logic                       cfg_we = 1'b0;
  logic [1:0]                 cfg_kind = '0;
  logic [REGW-1:0]            cfg_addr = '0;
  logic [63:0]                cfg_data = '0;
  logic [NSLOT-1:0][REGW-1:0] slot_base = '0;
  logic                       out_valid;
  logic                       out_ready = 1'b0;
  logic [4:0]                 out_elem;
  logic                       out_last;
  logic [NSLOT-1:0][REGW-1:0] out_reg;
  logic [NSLOT-1:0]           out_half;
  logic                       loop_done;

  elem_sequencer #(.MAXVL(MAXVL), .REGW(REGW), .NSLOT(NSLOT)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .slot_base(slot_base),
    .out_valid(out_valid), .out_ready(out_ready), .out_elem(out_elem),
    .out_last(out_last), .out_reg(out_reg), .out_half(out_half),
    .loop_done(loop_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int rdy_mode = 0;   // 0 stall, 1 always, 2 pseudo-random
  logic [7:0] lfsr = 8'hA7;
  bit mon_en = 1'b0;
  item_t exp_q[$];

  // bench model of configuration
  logic [63:0] btbl [4][4];
  int bhome[4], belw[4], bmodn[4];
  bit bmod[4];
  bit ren[4];
  int rsel[4];
  int bbase[4];
  int bopw;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? lfsr[0] : 1'b0;
  end

  // monitor: compare every accepted beat against the scoreboard
  always @(negedge clk) begin
    if (mon_en && rst_n && out_valid && out_ready) begin
      item_t act, expv;
      act.elem = out_elem; act.last = out_last;
      act.regs = out_reg;  act.halves = out_half;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected beat", 64'(act), 64'd0);
      end else begin
        expv = exp_q.pop_front();
        chk(act == expv, "R3 R4 R6 R7 R8 R9 beat", 64'(act), 64'(expv));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R5 actual=%0h expected=%0h", 0, 1);
    report();
  end

  function automatic int exp_idx(int s, int e);
    int c, w, sub;
    logic [63:0] v;
    if (bmod[s]) return (bmodn[s] <= 1) ? 0 : e % bmodn[s];
    c = belw[s];
    w = (e >> c) % 4;
    sub = e & ((1 << c) - 1);
    v = btbl[s][w] >> (sub * (64 >> c));
    return int'(v[7:0]);
  endfunction

  function automatic item_t make_item(int e, int vl);
    item_t it;
    it.elem = 5'(e);
    it.last = (e == vl - 1);
    for (int k = 0; k < 4; k++) begin
      int idx, p;
      idx = ren[k] ? exp_idx(rsel[k], e) : e;
      p = ((bopw != 0) ? bbase[k] * 2 : bbase[k]) + idx;
      p = p & 255;
      it.regs[k]   = (bopw != 0) ? 7'(p >> 1) : 7'(p);
      it.halves[k] = (bopw != 0) ? p[0] : 1'b0;
    end
    return it;
  endfunction

  task automatic cfg(logic [1:0] kind, logic [6:0] addr, logic [63:0] data);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_kind = kind; cfg_addr = addr; cfg_data = data;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic set_shape(int s, int elw, bit is_mod, int modn, int home_half);
    belw[s] = elw; bmod[s] = is_mod; bmodn[s] = modn; bhome[s] = home_half * 2;
    cfg(2'd1, 7'(s), (64'(home_half) << 16) | (64'(modn) << 8) | (64'(is_mod) << 2) | 64'(elw));
  endtask

  task automatic wr_table(int regn, logic [63:0] data);
    for (int s = 0; s < 4; s++)
      if (regn >= bhome[s] && regn - bhome[s] < 4) btbl[s][regn - bhome[s]] = data;
    cfg(2'd0, 7'(regn), data);
  endtask

  task automatic set_remap(bit e0, int s0, bit e1, int s1, bit e2, int s2, bit e3, int s3);
    logic [63:0] d;
    ren[0] = e0; rsel[0] = s0; ren[1] = e1; rsel[1] = s1;
    ren[2] = e2; rsel[2] = s2; ren[3] = e3; rsel[3] = s3;
    d = '0;
    for (int k = 0; k < 4; k++) d[3*k +: 3] = {ren[k], 2'(rsel[k])};
    cfg(2'd2, 7'd0, d);
  endtask

  task automatic start_loop(int vraw, int opw, int count);
    int vl;
    vl = (vraw == 0) ? 1 : (vraw > MAXVL) ? MAXVL : vraw;
    bopw = opw;
    for (int p = 0; p < count; p++)
      for (int e = 0; e < vl; e++) exp_q.push_back(make_item(e, vl));
    cfg(2'd3, 7'd0, (64'(count) << 16) | (64'(opw) << 8) | 64'(vraw));
  endtask

  task automatic finish_loop(string tag);
    while (!loop_done) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, {tag, " R4 all beats seen"}, 64'(exp_q.size()), 64'd0);
    chk(!out_valid && loop_done, {tag, " R5 stop at zero count"}, {62'd0, out_valid, loop_done}, 64'd1);
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 4; w++) btbl[s][w] = '0;
      bhome[s] = 0; belw[s] = 0; bmodn[s] = 0; bmod[s] = 0;
      ren[s] = 0; rsel[s] = 0; bbase[s] = 0;
    end
    bopw = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid, "R1 reset valid", 64'(out_valid), 64'd0);
    chk(!loop_done, "R1 reset done", 64'(loop_done), 64'd0);
    #1 rst_n = 1'b1;
    mon_en = 1'b1;

    // pattern 1: mixed shapes, 32-bit operation, two passes, random stalls
    set_shape(0, 3, 0, 0, 4);    // 8-bit indices, home 8
    set_shape(1, 1, 0, 0, 6);    // 32-bit indices, home 12
    set_shape(2, 0, 0, 0, 7);    // 64-bit indices, home 14 (overlaps shape 1)
    set_shape(3, 3, 1, 4, 0);    // modulo 4, home 0
    for (int w = 0; w < 4; w++) begin
      logic [63:0] d;
      for (int j = 0; j < 8; j++) d[8*j +: 8] = 8'((((8*w + j) * 5) + 3) & 15);
      wr_table(8 + w, d);
    end
    for (int w = 0; w < 4; w++) wr_table(12 + w, {32'(100 + w), 32'(40 + 3*w)});
    for (int w = 0; w < 4; w++) wr_table(14 + w, 64'hDEAD_BEEF_0000_0000 | 64'(w * 9 + 2));
    wr_table(30, 64'hFFFF_FFFF_FFFF_FFFF);  // R11 no window covers it
    wr_table(7,  64'hFFFF_FFFF_FFFF_FFFF);  // R11 just below a home
    wr_table(2,  64'h0F0F_0F0F_0F0F_0F0F);  // R8 shape in modulo mode ignores table
    bbase[0] = 24; bbase[1] = 24; bbase[2] = 40; bbase[3] = 60;
    for (int k = 0; k < 4; k++) slot_base[k] = 7'(bbase[k]);
    set_remap(1, 0, 1, 1, 1, 3, 0, 0);      // R10
    rdy_mode = 2;
    start_loop(40, 1, 2);                   // R2 clamp 40 to 32
    finish_loop("p1");

    // pattern 2: 64-bit operation, 64-bit indices, modulo 3, stall first
    set_shape(3, 0, 1, 3, 0);
    set_remap(1, 2, 1, 3, 0, 0, 1, 1);
    bbase[0] = 5; bbase[1] = 100; bbase[2] = 126; bbase[3] = 0;
    for (int k = 0; k < 4; k++) slot_base[k] = 7'(bbase[k]);
    rdy_mode = 0;
    @(posedge clk); #1;
    start_loop(5, 0, 1);
    @(negedge clk);
    chk(out_valid && out_elem == 0, "R2 start at element 0", {58'd0, out_valid, out_elem}, 64'h20);
    begin
      logic [NSLOT-1:0][REGW-1:0] r0;
      r0 = out_reg;
      repeat (3) @(negedge clk);
      chk(out_valid && out_elem == 0, "R3 stall holds element", {58'd0, out_valid, out_elem}, 64'h20);
      chk(out_reg == r0, "R3 stall holds registers", 64'(out_reg), 64'(r0));
    end
    rdy_mode = 1;
    finish_loop("p2");

    // pattern 3: zero count completes at once
    rdy_mode = 1;
    start_loop(8, 1, 0);
    @(negedge clk);
    chk(loop_done && !out_valid, "R5 zero count", {62'd0, loop_done, out_valid}, 64'd2);

    // pattern 4: length 0 taken as 1, three passes, all slots linear
    set_remap(0, 0, 0, 0, 0, 0, 0, 0);
    bbase[0] = 127; bbase[1] = 64; bbase[2] = 1; bbase[3] = 33;
    for (int k = 0; k < 4; k++) slot_base[k] = 7'(bbase[k]);
    rdy_mode = 2;
    start_loop(0, 1, 3);                    // R2 R6
    finish_loop("p4");

    report();
  end
endmodule